// File: doc/BRIEF.md
# Handshake-Gated Three-Link Queue

This block is a first-in first-out queue of three storage links. Each link holds one data word and a flag that says whether the word is valid. Handshake joints sit at both ends of the chain and between each pair of links. The entry joint takes a word from a producer. Each internal joint moves a word from one link to the next. The exit joint hands the oldest word to a consumer. The design is synchronous logic that models a self-timed pipeline.

Every joint has its own enable input, called its go bit. Holding a go bit low stands in for an arbitrary delay at that joint. The enclosing logic or a test environment can therefore force any stall pattern on the pipeline. Word order must survive every such pattern.

On each clock edge, every joint decides from the current link flags whether it fires. A firing joint copies its source word into its destination link, marks the destination full and marks its source empty, all in that one edge.

Top module: `lj_queue`

## Requirements
- R1: An active-high synchronous reset marks all three links empty. After reset `consValid` is 0, and `prodAccept` equals `jointGo[0]`.
- R2: An internal joint j (1 or 2) fires only when `jointGo[j]` is 1, link j-1 is full and link j is empty.
- R3: A joint whose go bit is 0 never fires. With every go bit at 0, no word enters, moves or leaves, whatever the handshake inputs are.
- R4: When a joint fires, three things happen at the same edge: the word is copied into the destination link, the destination becomes full, and the source becomes empty.
- R5: The queue holds at most three words. If nothing leaves, exactly three words are accepted and then `prodAccept` stays 0.
- R6: At each edge, the number of full links changes by the words accepted minus the words delivered. A queue that starts empty is empty again once everything accepted has been delivered.
- R7: The sequence of delivered words equals the sequence of accepted words, with no loss, duplication or reordering.
- R8: `prodAccept` is `jointGo[0]` AND (link 0 empty). A word is accepted when `prodValid` and `prodAccept` are both 1. `consValid` is `jointGo[3]` AND (link 2 full). A word is delivered when `consValid` and `consTake` are both 1. `jointGo` bit 0 is the entry joint, bits 1 and 2 are the internal joints, and bit 3 is the exit joint.
- R9: With all go bits at 1 and the queue empty, a word accepted at an edge is offered on `consValid` in the third cycle after that edge.
- R10: A link emptied at an edge is not refilled at that same edge. With all go bits, `prodValid` and `consTake` held at 1 from reset, exactly 10 words are accepted in the first 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| prodValid | input | 1 | Producer offers a word |
| prodData | input | DATA_W | Producer word |
| prodAccept | output | 1 | Entry joint can take a word this cycle |
| consValid | output | 1 | Exit joint offers the oldest word |
| consData | output | DATA_W | Oldest word (word held in link 2) |
| consTake | input | 1 | Consumer takes the offered word |
| jointGo | input | 4 | Per-joint go bits; bit 0 entry, bit 3 exit |

## Verification
The in-line assertions check the following on every cycle:
- a link fills only from a full predecessor;
- a link drains only when the next joint's go bit was high;
- both flags of a link hold still when the go bits on both of its sides are low;
- the occupancy count moves by exactly accepts minus deliveries;
- link words change only on a load strobe.

Some properties only the bench's scenarios can show. These are end-to-end ordering under swept and random go patterns, the capacity limit, the three-cycle fill latency, and the one-word-per-two-cycles rate caused by the bubble rule.

// File: rtl/lj_pkg.sv
package lj_pkg;
  parameter int LJ_LINKS = 3;
  localparam int LJ_JOINTS = LJ_LINKS + 1;

  // Strobes from the control to the datapath: one load per link.
  typedef struct packed {
    logic [LJ_LINKS-1:0] load;
  } lj_strobe_t;
endpackage

// File: rtl/lj_control.sv
module lj_control
  import lj_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prodValid,
  input  logic                 consTake,
  input  logic [LJ_JOINTS-1:0] jointGo,
  output logic                 prodAccept,
  output logic                 consValid,
  output lj_strobe_t           strobe
);
  localparam int LAST = LJ_LINKS - 1;

  logic [LJ_LINKS-1:0]  linkFull;
  logic [LJ_LINKS-1:0]  linkFullNext;
  logic [LJ_JOINTS-1:0] fire;

  // Every joint decides from the link flags as they stand before the edge.
  for (genvar j = 0; j < LJ_JOINTS; j++) begin : g_joint
    if (j == 0) begin : g_entry
      assign fire[j] = prodValid & jointGo[j] & ~linkFull[0];
    end else if (j == LJ_JOINTS - 1) begin : g_exit
      assign fire[j] = consTake & jointGo[j] & linkFull[LAST];
    end else begin : g_mid
      assign fire[j] = jointGo[j] & linkFull[j-1] & ~linkFull[j];
    end
  end

  // A link fills when its upstream joint fires and empties when its
  // downstream joint fires. The two never coincide on one link.
  for (genvar i = 0; i < LJ_LINKS; i++) begin : g_flag
    assign linkFullNext[i] = (linkFull[i] & ~fire[i+1]) | fire[i];
  end

  always_ff @(posedge clk) begin
    if (rst) linkFull <= '0;
    else     linkFull <= linkFullNext;
  end

  assign prodAccept  = jointGo[0] & ~linkFull[0];
  assign consValid   = jointGo[LJ_JOINTS-1] & linkFull[LAST];
  assign strobe.load = fire[LJ_LINKS-1:0];

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> linkFull == '0); // R1

  AST_OCCUPANCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'($countones(linkFull)) ==
      int'($countones($past(linkFull))) + int'($past(prodValid & prodAccept))
      - int'($past(consValid & consTake))); // R6

  for (genvar i = 1; i < LJ_LINKS; i++) begin : g_fill_chk
    AST_FILL_FROM_FULL: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(linkFull[i])) |-> $past(linkFull[i-1])); // R2
  end

  for (genvar i = 0; i < LJ_LINKS; i++) begin : g_drain_chk
    AST_DRAIN_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(linkFull[i])) |-> $past(jointGo[i+1])); // R3
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(jointGo[i]) && !$past(jointGo[i+1]))
        |-> $stable(linkFull[i])); // R3
  end
endmodule

// File: rtl/lj_datapath.sv
module lj_datapath
  import lj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lj_strobe_t        strobe,
  input  logic [DATA_W-1:0] prodData,
  output logic [DATA_W-1:0] consData
);
  logic [DATA_W-1:0] linkWord [LJ_LINKS];

  // Words carry no reset; a word is meaningful only while its link is full.
  for (genvar i = 0; i < LJ_LINKS; i++) begin : g_link
    logic [DATA_W-1:0] srcWord;
    if (i == 0) begin : g_head
      assign srcWord = prodData;
    end else begin : g_body
      assign srcWord = linkWord[i-1];
    end

    always_ff @(posedge clk) begin
      if (strobe.load[i]) linkWord[i] <= srcWord;
    end

    AST_WORD_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(strobe.load[i])) |-> $stable(linkWord[i])); // R4
  end

  assign consData = linkWord[LJ_LINKS-1];
endmodule

// File: rtl/lj_queue.sv
module lj_queue
  import lj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prodValid,
  input  logic [DATA_W-1:0]    prodData,
  output logic                 prodAccept,
  output logic                 consValid,
  output logic [DATA_W-1:0]    consData,
  input  logic                 consTake,
  input  logic [LJ_JOINTS-1:0] jointGo
);
  lj_strobe_t strobe;

  lj_control u_control (
    .clk        (clk),
    .rst        (rst),
    .prodValid  (prodValid),
    .consTake   (consTake),
    .jointGo    (jointGo),
    .prodAccept (prodAccept),
    .consValid  (consValid),
    .strobe     (strobe)
  );

  lj_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .prodData (prodData),
    .consData (consData)
  );
endmodule

// File: tb/lj_queue_tb.sv
module lj_queue_tb;
  localparam int DW = 8;
  localparam int NJ = lj_pkg::LJ_JOINTS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prodValid = 1'b0;
  logic [DW-1:0] prodData = '0;
  logic          prodAccept;
  logic          consValid;
  logic [DW-1:0] consData;
  logic          consTake = 1'b0;
  logic [NJ-1:0] jointGo = '0;

  int checks = 0;
  int fails = 0;
  logic [2:0] mFull;
  logic [DW-1:0] refQ[$];
  int accCnt, delCnt;

  always #5 clk = ~clk;

  lj_queue #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .prodValid(prodValid), .prodData(prodData),
    .prodAccept(prodAccept), .consValid(consValid), .consData(consData),
    .consTake(consTake), .jointGo(jointGo)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; prodValid = 1'b0; consTake = 1'b0; jointGo = '1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    mFull = '0;
    refQ.delete();
    #1;
    check(consValid == 1'b0, "R1 consValid after reset", int'(consValid), 0);
    check(prodAccept == 1'b1, "R1 prodAccept after reset", int'(prodAccept), 1);
  endtask

  // One cycle: drive at the falling edge, check settled outputs, then
  // advance the flag model by the rules of R2, R4 and R8.
  task automatic step(input bit v, input logic [DW-1:0] d, input bit t,
                      input logic [NJ-1:0] g);
    bit f0, f1, f2, f3, expAcc, expVal;
    if (!(clk == 1'b0)) @(negedge clk);
    prodValid = v; prodData = d; consTake = t; jointGo = g;
    #1;
    expAcc = g[0] & ~mFull[0];
    expVal = g[3] & mFull[2];
    check(prodAccept == expAcc, "R2 R8 prodAccept", int'(prodAccept), int'(expAcc));
    check(consValid == expVal, "R4 R8 consValid", int'(consValid), int'(expVal));
    if (expVal && refQ.size() > 0)
      check(consData == refQ[0], "R7 delivered word order", int'(consData), int'(refQ[0]));
    f0 = v & expAcc;
    f1 = g[1] & mFull[0] & ~mFull[1];
    f2 = g[2] & mFull[1] & ~mFull[2];
    f3 = t & expVal;
    if (f0) begin refQ.push_back(d); accCnt++; end
    if (f3 && refQ.size() > 0) begin void'(refQ.pop_front()); delCnt++; end
    mFull[0] = (mFull[0] & ~f1) | f0;
    mFull[1] = (mFull[1] & ~f2) | f1;
    mFull[2] = (mFull[2] & ~f3) | f2;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 12; k++) step(1'b0, '0, 1'b1, '1);
    check(refQ.size() == 0, "R6 queue empty after drain", refQ.size(), 0);
    check(consValid == 1'b0, "R6 consValid after drain", int'(consValid), 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [DW-1:0] seed;
    do_reset();

    // R10: bubble rule gives one accept per two cycles
    accCnt = 0;
    for (int k = 0; k < 20; k++) step(1'b1, DW'(k), 1'b1, '1);
    check(accCnt == 10, "R10 accepts in 20 cycles", accCnt, 10);
    drain();

    // R5: capacity of three with the exit stalled
    do_reset();
    accCnt = 0;
    for (int k = 0; k < 8; k++) step(1'b1, DW'(8'h40 + k), 1'b0, '1);
    check(accCnt == 3, "R5 words held", accCnt, 3);
    #1 check(prodAccept == 1'b0, "R5 prodAccept when full", int'(prodAccept), 0);

    // R3: all go bits low freeze everything
    accCnt = 0; delCnt = 0;
    for (int k = 0; k < 10; k++) step(1'b1, 8'hEE, 1'b1, '0);
    check(accCnt == 0 && delCnt == 0, "R3 stall moved words", accCnt + delCnt, 0);
    drain();

    // R9: fill latency
    do_reset();
    step(1'b1, 8'h5A, 1'b0, '1);
    lat = 1;
    while (lat < 10) begin
      #1;
      if (consValid) break;
      step(1'b0, '0, 1'b0, '1);
      lat++;
    end
    check(lat == 3, "R9 cycles to offer", lat, 3);
    drain();

    // Sweep all 16 go patterns, each held in turn, with full handshakes
    for (int rep = 0; rep < 2; rep++)
      for (int p = 0; p < 16; p++)
        for (int k = 0; k < 8; k++)
          step(1'b1, DW'(p * 16 + k + rep), 1'b1, NJ'(p));
    drain();

    // Random go and handshake patterns
    seed = 8'h01;
    for (int k = 0; k < 3000; k++) begin
      seed = seed + 8'd37;
      step(1'($urandom), seed, 1'($urandom), NJ'($urandom));
    end
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule